// File: doc/BRIEF.md
# Pipelined Linear-to-Log Converter

This block turns an unsigned linear magnitude into a compact base-2 logarithmic code. It accepts one sample on every clock, qualified by a valid strobe. A fixed number of cycles later it returns an 8-bit code together with an output valid and a zero flag. The upper bits of the code are the integer part of log2, which is the position of the most significant set bit. The lower bits are the fractional part, rounded to eighths.

The integer part comes from a normalizing shifter split across one register stage per shift size. Each stage tests whether the upper window of the running value is empty. If it is empty, the stage shifts the value left. If it is not, the stage adds the window size to the running exponent. Once the value is normalized, the few bits just below its leading one address a small table of rounded log fractions. The table is computed when the design is elaborated.

Typical uses are gain metering, automatic gain control loops and companding, where a coarse logarithm with one result per clock is enough.

Top module: `lin2log_pipe`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, out_valid is low.
- R2: A sample presented with in_valid high at a rising clock edge produces out_valid high exactly 7 rising edges later. Any pattern of valid and idle cycles, including back-to-back samples, is reproduced at the output with the same spacing.
- R3: For a nonzero input, out_code[7:3] holds the bit index (0 to 31) of the most significant set bit of in_data.
- R4: For a nonzero input, out_code[2:0] equals round(8 * log2(1 + f/8)), where f is the 3-bit number formed by the three input bits directly below the leading one, with zeros filling positions below bit 0. This gives the values 0,1,3,4,5,6,6,7 for f = 0..7.
- R5: An input of zero gives out_code = 0 and out_zero = 1. Every nonzero input gives out_zero = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low; clears the valid pipeline |
| in_valid | input | 1 | Qualifies in_data in this cycle |
| in_data | input | 32 | Unsigned linear magnitude |
| out_valid | output | 1 | Qualifies out_code and out_zero |
| out_code | output | 8 | Exponent in bits 7:3, rounded mantissa in bits 2:0 |
| out_zero | output | 1 | High when the sample was zero |

## Verification
The bench builds the block with its default parameters: a 32-bit input and a 3-bit mantissa, which means five shift stages and an 8-entry fraction table. At this size a directed sweep covers every pair of leading-one position and mantissa index in 256 samples, including the low positions where the mantissa bits are zero-filled. Random magnitudes with random idle gaps then test the valid spacing and the zero case. Expected codes are computed in the bench with real-valued logarithms.

// File: rtl/lin2log_pipe.sv
module lin2log_pipe #(
  parameter int IN_W   = 32,
  parameter int MANT_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [IN_W-1:0]               in_data,
  output logic                          out_valid,
  output logic [$clog2(IN_W)+MANT_W-1:0] out_code,
  output logic                          out_zero
);
  localparam int EXP_W = $clog2(IN_W);
  localparam int NW    = 1 << EXP_W;
  localparam int LUT_N = 1 << MANT_W;
  localparam int FB    = 30;

  function automatic int frac_of(int idx);
    logic [63:0] x;
    int r;
    x = 64'(LUT_N + idx) << (FB - MANT_W);
    r = 0;
    for (int b = 0; b <= MANT_W; b++) begin
      x = (x * x) >> FB;
      r = r << 1;
      if (x >= (64'd2 << FB)) begin
        r = r | 1;
        x = x >> 1;
      end
    end
    r = (r + 1) >> 1;
    if (r > LUT_N - 1) r = LUT_N - 1;
    return r;
  endfunction

  logic [MANT_W-1:0] frac_lut [LUT_N];

  for (genvar i = 0; i < LUT_N; i++) begin : g_lut
    localparam int F = frac_of(i);
    assign frac_lut[i] = MANT_W'(F);
  end

  for (genvar k = 0; k <= EXP_W; k++) begin : g_st
    logic [NW-1:0]    val;
    logic [EXP_W-1:0] ex;
    logic             vld;
    if (k == 0) begin : g_load
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) vld <= 1'b0;
        else        vld <= in_valid;
      always_ff @(posedge clk) begin
        val <= NW'(in_data);
        ex  <= '0;
      end
    end else begin : g_shift
      localparam int SH = 1 << (EXP_W - k);
      logic hit;
      assign hit = |g_st[k-1].val[NW-1 -: SH];
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) vld <= 1'b0;
        else        vld <= g_st[k-1].vld;
      always_ff @(posedge clk) begin
        val <= hit ? g_st[k-1].val : (g_st[k-1].val << SH);
        ex  <= g_st[k-1].ex + (hit ? EXP_W'(SH) : '0);
      end
    end
  end

  logic [NW-1:0]     norm;
  logic              is_zero;
  logic [MANT_W-1:0] idx;

  assign norm    = g_st[EXP_W].val;
  assign is_zero = ~|norm;
  assign idx     = norm[NW-2 -: MANT_W];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= g_st[EXP_W].vld;

  always_ff @(posedge clk) begin
    out_zero <= is_zero;
    out_code <= is_zero ? '0 : {g_st[EXP_W].ex, frac_lut[idx]};
  end
endmodule

// File: rtl/lin2log_pipe_chk.sv
module lin2log_pipe_chk #(
  parameter int IN_W   = 32,
  parameter int MANT_W = 3
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           in_valid,
  input logic [IN_W-1:0]                in_data,
  input logic                           out_valid,
  input logic [$clog2(IN_W)+MANT_W-1:0] out_code,
  input logic                           out_zero
);
  localparam int EXP_W = $clog2(IN_W);
  localparam int LAT   = EXP_W + 2;

  logic [7:0] since_rst;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 since_rst <= '0;
    else if (since_rst < 8'(LAT)) since_rst <= since_rst + 8'd1;

  logic warm;
  assign warm = (since_rst >= 8'(LAT));

  a_r2_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (out_valid == $past(in_valid, LAT)));

  a_r5_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid) |-> (out_zero == ($past(in_data, LAT) == '0)));

  a_r5_zero_code: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_zero) |-> (out_code == '0));

  a_r3_leading_one: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid && !out_zero) |->
      (((IN_W+1)'($past(in_data, LAT)) >> out_code[MANT_W +: EXP_W]) == (IN_W+1)'(1)));

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 8'd0) |-> !out_valid);
endmodule

bind lin2log_pipe lin2log_pipe_chk #(.IN_W(IN_W), .MANT_W(MANT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .out_valid(out_valid), .out_code(out_code), .out_zero(out_zero)
);

// File: tb/lin2log_pipe_tb_top.sv
`timescale 1ns/1ps
module lin2log_pipe_tb_top;
  localparam int LAT = 7;
  localparam int N   = 3000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic [7:0]  out_code;
  logic        out_zero;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lin2log_pipe dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_code(out_code), .out_zero(out_zero)
  );

  logic        hv [8];
  logic [31:0] hd [8];

  function automatic int lead(logic [31:0] v);
    for (int b = 31; b >= 0; b--) if (v[b]) return b;
    return -1;
  endfunction

  function automatic int exp_frac(logic [31:0] v);
    int e;
    logic [63:0] n;
    int f;
    real r;
    e = lead(v);
    n = 64'(v) << (31 - e);
    f = int'(n[30:28]);
    r = 8.0 * $ln((8.0 + f) / 8.0) / $ln(2.0);
    return $rtoi(r + 0.5);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] stim(int n, output logic v);
    logic [63:0] x;
    int e, f;
    v = 1'b1;
    if (n < 256) begin
      e = n / 8;
      f = n % 8;
      x = 64'd1 << e;
      if (e >= 3) x = x | (64'(f) << (e - 3));
      else        x = x | (64'(f) >> (3 - e));
      if (e > 3)  x = x | (64'($urandom) & ((64'd1 << (e - 3)) - 1));
      return x[31:0];
    end else if (n < 264) begin
      v = n[0];
      return (n < 262) ? 32'd0 : 32'hFFFF_FFFF;
    end else begin
      v = ($urandom % 4) != 0;
      if ($urandom % 16 == 0) return 32'd0;
      return $urandom >> ($urandom % 32);
    end
  endfunction

  initial begin
    logic v;
    logic [31:0] d;
    for (int i = 0; i < 8; i++) begin hv[i] = 1'b0; hd[i] = '0; end
    repeat (4) @(negedge clk);
    check("R1 reset out_valid", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 first cycle out_valid", 32'(out_valid), 32'd0);
    for (int cyc = 0; cyc < N + LAT + 1; cyc++) begin
      int k;
      k = cyc - LAT;
      if (k >= 0) begin
        check("R2 out_valid spacing", 32'(out_valid), 32'(hv[k % 8]));
        if (hv[k % 8] && out_valid) begin
          if (hd[k % 8] == 0) begin
            check("R5 zero flag", 32'(out_zero), 32'd1);
            check("R5 zero code", 32'(out_code), 32'd0);
          end else begin
            check("R5 nonzero flag", 32'(out_zero), 32'd0);
            check("R3 exponent", 32'(out_code[7:3]), 32'(lead(hd[k % 8])));
            check("R4 mantissa", 32'(out_code[2:0]), 32'(exp_frac(hd[k % 8])));
          end
        end
      end else begin
        check("R2 idle before first result", 32'(out_valid), 32'd0);
      end
      if (cyc < N) begin
        d = stim(cyc, v);
        in_valid = v;
        in_data  = d;
        hv[cyc % 8] = v;
        hd[cyc % 8] = d;
      end else begin
        in_valid = 1'b0;
        in_data  = '0;
        hv[cyc % 8] = 1'b0;
        hd[cyc % 8] = '0;
      end
      @(negedge clk);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule